// File: doc/BRIEF.md
# Quad down-counting timer

The block holds four independent decrementing counters behind a small word-addressed register bus. Each counter has a load register, a readable current value, a control register and a reload value that is held in the background. Control bits switch the counter on, choose what happens when it passes zero (stop, reload, or wrap), select a prescale of 1, 16 or 256 clock cycles per count, and select a 16-bit or 32-bit counting width.

When a counter that stands at zero receives a count tick, it underflows. The underflow sets that channel's bit in a shared raw status register. The raw status is gated by a mask register and the result is ORed onto a single interrupt line. Software acknowledges an event by writing ones to a clear register.

Typical use: write the load value, write the background reload value, then write the control register. After that, either poll the current value or wait for the interrupt.

Top module: `quad_down_timer`

## Requirements
- R1: After reset, every register reads zero, all channels are disabled and `irq_o` is low.
- R2: The register map is as follows. Word 0x00 is the mask (read/write). 0x04 is the raw status (read-only). 0x08 is raw AND mask (read-only). 0x0C is the write-one-to-clear register, which reads zero. Channel x occupies base 0x10+0x10·x, with load at +0x0, current value at +0x4 (read-only), control at +0x8 and background reload at +0xC. Unmapped or unaligned addresses read zero, and writes to them or to read-only words change nothing. A control read returns only bits 7, 6, 3:2, 1 and 0.
- R3: A load write does not reach the current value at the write edge. It appears on the following clock edge, whether or not the channel is enabled. That transfer takes priority over a count tick on the same edge.
- R4: Control bit 7 enables the channel. Bit 6 selects periodic reload (0 = free-running). Bits 3:2 select the prescale: 00 = 1, 01 = 16, 10 = 256, 11 also 256. Bit 1 selects 32-bit width (0 = 16-bit). Bit 0 selects one-shot.
- R5: An enabled channel decrements by one per prescaled tick. A disabled channel holds its value.
- R6: With prescale D, a control write that changes the enable bit or the prescale field restarts the divider, so the ticks fall D, 2D, 3D… edges after the write edge. A control write that leaves both fields unchanged does not restart it.
- R7: A tick while the width-masked value is zero is an underflow, and it sets that channel's raw bit on the same edge.
- R8: On underflow in free-running mode, the counter wraps to 0xFFFF in 16-bit width or to 0xFFFFFFFF in 32-bit width.
- R9: On underflow in periodic mode, the counter reloads from the background reload register, masked to the width.
- R10: A background reload write leaves the running count untouched. It is used only at the next underflow.
- R11: On underflow in one-shot mode, the counter holds at zero and produces no further ticks or underflows until the next load or control write. One-shot takes precedence over periodic.
- R12: In 16-bit width, each tick operates on the low 16 bits only, so the value after a tick has zero upper bits.
- R13: The masked status is raw AND mask, and `irq_o` is its OR. Writing 1 to a clear bit clears that raw bit. An underflow on the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers and counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (8) | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Combined interrupt, OR of the masked status |

## Verification
The bench goes after four corner cases, each of which a faulty design would show in a specific way:
- **Delayed load.** The bench reads the current value in the cycle between a load write and its transfer. A design that loads at once shows the new value one cycle early.
- **Divider restart.** The bench changes the prescale on a running channel, then rewrites the control register with both fields unchanged. A divider that restarts on every write, or never restarts, drifts by whole periods and shows it in the cycle-by-cycle value reads.
- **Underflow and reload behaviour.** The bench covers background reloads written mid-count, one-shot with the periodic bit also set, and a 16-bit counter loaded with upper bits present. A design that reloads early, keeps counting after a one-shot, or carries the upper half shows the wrong value or a second raw event.
- **Clear against set.** Clears are issued while other channels keep underflowing. A clear that drops a simultaneous event loses an interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int DATA_W = 32;

  // control word layout kept by the channels
  typedef struct packed {
    logic       en;
    logic       per;
    logic [1:0] psc;
    logic       w32;
    logic       os;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
    ctrl_t c;
    c.en  = w[7];
    c.per = w[6];
    c.psc = w[3:2];
    c.w32 = w[1];
    c.os  = w[0];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
    return {24'd0, c.en, c.per, 2'b00, c.psc, c.w32, c.os};
  endfunction

  // last divider count for a prescale code (divide-by minus one)
  function automatic logic [7:0] psc_last(input logic [1:0] code);
    case (code)
      2'b00:   return 8'd0;
      2'b01:   return 8'd15;
      default: return 8'd255;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] width_mask(input logic w32);
    return w32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  // value after one tick, cur already width-masked
  function automatic logic [DATA_W-1:0] next_count(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] bg,
    input logic [DATA_W-1:0] wm,
    input logic              per,
    input logic              os
  );
    if (cur != '0) return cur - 32'd1;
    if (os)        return '0;
    if (per)       return bg & wm;
    return wm;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [PSC_W-1:0] last,
  output logic             tick_o
);

  logic [PSC_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == last);
  assign tick_o = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_wr,
  input  logic              ctl_wr,
  input  logic              bg_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] val_q,
  output logic [DATA_W-1:0] bg_q,
  output ctrl_t             ctrl_q,
  output logic              tick_o,
  output logic              unf_o,
  output logic              pend_o
);

  logic              pend_q;
  logic              done_q;
  logic              pre_tick;
  logic              restart;
  ctrl_t             ctrl_new;
  logic [DATA_W-1:0] wm;
  logic [DATA_W-1:0] cur;

  assign ctrl_new = ctrl_unpack(wdata);
  assign restart  = ctl_wr && ((ctrl_new.en != ctrl_q.en) || (ctrl_new.psc != ctrl_q.psc));

  tmr_prescaler #(.PSC_W(8)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (ctrl_q.en),
    .last    (psc_last(ctrl_q.psc)),
    .tick_o  (pre_tick)
  );

  assign tick_o = pre_tick && !done_q;
  assign wm     = width_mask(ctrl_q.w32);
  assign cur    = val_q & wm;
  assign unf_o  = tick_o && !pend_q && (cur == '0);
  assign pend_o = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      val_q  <= '0;
      bg_q   <= '0;
      ctrl_q <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (pend_q) begin
        val_q <= load_q;
      end else if (tick_o) begin
        val_q <= next_count(cur, bg_q, wm, ctrl_q.per, ctrl_q.os);
      end
      pend_q <= ld_wr;
      if (ld_wr)  load_q <= wdata;
      if (bg_wr)  bg_q   <= wdata;
      if (ctl_wr) ctrl_q <= ctrl_new;
      if (ld_wr || ctl_wr) begin
        done_q <= 1'b0;
      end else if (unf_o && ctrl_q.os) begin
        done_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] unf,
  input  logic           mask_wr,
  input  logic           clr_wr,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] raw_q,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] masked,
  output logic           irq_o
);

  logic [NCH-1:0] clr_bits;

  assign clr_bits = clr_wr ? wbits : '0;
  assign masked   = raw_q & mask_q;
  assign irq_o    = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | unf;
      if (mask_wr) mask_q <= wbits;
    end
  end

endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer
  import tmr_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);

  localparam int REG_W = ADDR_W - 4;

  logic [REG_W-1:0] region;
  logic [1:0]       slot;
  logic             word_ok;
  logic             mask_wr;
  logic             clr_wr;

  logic [NCH-1:0]             ch_tick;
  logic [NCH-1:0]             ch_unf;
  logic [NCH-1:0]             ch_pend;
  logic [NCH-1:0]             ch_en;
  logic [NCH-1:0][DATA_W-1:0] ch_val;
  logic [DATA_W-1:0]          ch_load [NCH];
  logic [DATA_W-1:0]          ch_bg   [NCH];
  ctrl_t                      ch_ctrl [NCH];

  logic [NCH-1:0] raw;
  logic [NCH-1:0] mask;
  logic [NCH-1:0] masked;

  assign region  = bus_addr[ADDR_W-1:4];
  assign slot    = bus_addr[3:2];
  assign word_ok = (bus_addr[1:0] == 2'b00);
  assign mask_wr = bus_wr && word_ok && (region == '0) && (slot == 2'd0);
  assign clr_wr  = bus_wr && word_ok && (region == '0) && (slot == 2'd3);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel;
    assign sel = bus_wr && word_ok && (region == REG_W'(g + 1));

    tmr_channel u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_wr  (sel && (slot == 2'd0)),
      .ctl_wr (sel && (slot == 2'd2)),
      .bg_wr  (sel && (slot == 2'd3)),
      .wdata  (bus_wdata),
      .load_q (ch_load[g]),
      .val_q  (ch_val[g]),
      .bg_q   (ch_bg[g]),
      .ctrl_q (ch_ctrl[g]),
      .tick_o (ch_tick[g]),
      .unf_o  (ch_unf[g]),
      .pend_o (ch_pend[g])
    );

    assign ch_en[g] = ch_ctrl[g].en;
  end

  tmr_irq #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .unf     (ch_unf),
    .mask_wr (mask_wr),
    .clr_wr  (clr_wr),
    .wbits   (bus_wdata[NCH-1:0]),
    .raw_q   (raw),
    .mask_q  (mask),
    .masked  (masked),
    .irq_o   (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (word_ok) begin
      if (region == '0) begin
        case (slot)
          2'd0:    bus_rdata = DATA_W'(mask);
          2'd1:    bus_rdata = DATA_W'(raw);
          2'd2:    bus_rdata = DATA_W'(masked);
          default: bus_rdata = '0;
        endcase
      end else begin
        for (int i = 0; i < NCH; i++) begin
          if (region == REG_W'(i + 1)) begin
            case (slot)
              2'd0:    bus_rdata = ch_load[i];
              2'd1:    bus_rdata = ch_val[i];
              2'd2:    bus_rdata = ctrl_pack(ch_ctrl[i]);
              default: bus_rdata = ch_bg[i];
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int NCH = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr_wr,
  input logic [NCH-1:0]       clr_bits,
  input logic [NCH-1:0]       ch_tick,
  input logic [NCH-1:0]       ch_unf,
  input logic [NCH-1:0]       ch_pend,
  input logic [NCH-1:0]       ch_en,
  input logic [NCH-1:0][31:0] ch_val,
  input logic [NCH-1:0]       raw,
  input logic [NCH-1:0]       mask,
  input logic                 irq_o
);

  for (genvar i = 0; i < NCH; i++) begin : g_prop
    // R5: ticks only come from an enabled channel
    assert_tick_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ch_tick[i] |-> ch_en[i]);

    // R5: a disabled channel without a pending load holds its count
    assert_hold_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_en[i] && !ch_pend[i]) |=> $stable(ch_val[i]));

    // R7: an underflow leaves the raw bit set
    assert_raw_on_unf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ch_unf[i] |=> raw[i]);

    // R13: a clear without a competing underflow drops the raw bit
    assert_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_bits[i] && !ch_unf[i]) |=> !raw[i]);
  end

  // R13: the line is only high with a pending unmasked event
  assert_irq_source_R13: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((raw & mask) != '0));

  // R13: a masked-in raw bit drives the line
  assert_irq_level_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & mask) != '0) |-> irq_o);

endmodule

bind quad_down_timer tmr_checker #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_wr   (clr_wr),
  .clr_bits (bus_wdata[NCH-1:0]),
  .ch_tick  (ch_tick),
  .ch_unf   (ch_unf),
  .ch_pend  (ch_pend),
  .ch_en    (ch_en),
  .ch_val   (ch_val),
  .raw      (raw),
  .mask     (mask),
  .irq_o    (irq_o)
);

// File: tb/tb_quad_down_timer.sv
`timescale 1ns/1ps
module tb_quad_down_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit ended   = 0;

  always #10 clk = ~clk;

  quad_down_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // behavioural model state
  logic [31:0] m_load [4];
  logic [31:0] m_val  [4];
  logic [31:0] m_bg   [4];
  logic [31:0] m_ctrl [4];
  int          m_pre  [4];
  bit          m_pend [4];
  bit          m_done [4];
  logic [3:0]  m_raw, m_mask;

  function automatic int divisor(input logic [31:0] c);
    if (c[3:2] == 2'b00) return 1;
    if (c[3:2] == 2'b01) return 16;
    return 256;
  endfunction

  function automatic logic [31:0] mread(input logic [7:0] a);
    int c;
    if (a[1:0] != 0) return 0;
    if (a < 8'h10) begin
      if (a == 8'h00) return {28'd0, m_mask};
      if (a == 8'h04) return {28'd0, m_raw};
      if (a == 8'h08) return {28'd0, m_raw & m_mask};
      return 0;
    end
    c = int'(a >> 4) - 1;
    if (c >= 4) return 0;
    case (a & 8'h0C)
      8'h00:   return m_load[c];
      8'h04:   return m_val[c];
      8'h08:   return m_ctrl[c];
      default: return m_bg[c];
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [3:0] unf;
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_load[c] = 0; m_val[c] = 0; m_bg[c] = 0; m_ctrl[c] = 0;
        m_pre[c] = 0; m_pend[c] = 0; m_done[c] = 0;
      end
      m_raw = 0; m_mask = 0;
    end else begin
      unf = 0;
      for (int c = 0; c < 4; c++) begin
        bit lw, cw, bw, tick;
        int d;
        logic [31:0] wm, oc, nc;
        lw = bus_wr && bus_addr == 8'(8'h10 * (c + 1));
        cw = bus_wr && bus_addr == 8'(8'h10 * (c + 1) + 8);
        bw = bus_wr && bus_addr == 8'(8'h10 * (c + 1) + 12);
        oc = m_ctrl[c];
        nc = bus_wdata & 32'hCF;
        d  = divisor(oc);
        wm = oc[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        tick = oc[7] && !m_done[c] && (m_pre[c] == d - 1);
        if (m_pend[c]) m_val[c] = m_load[c];
        else if (tick) begin
          if ((m_val[c] & wm) == 0) begin
            unf[c] = 1;
            if (oc[0])      m_val[c] = 0;
            else if (oc[6]) m_val[c] = m_bg[c] & wm;
            else            m_val[c] = wm;
          end else m_val[c] = (m_val[c] & wm) - 1;
        end
        if (lw || cw) m_done[c] = 0;
        else if (unf[c] && oc[0]) m_done[c] = 1;
        if (cw && (nc[7] != oc[7] || nc[3:2] != oc[3:2])) m_pre[c] = 0;
        else if (oc[7]) m_pre[c] = (m_pre[c] == d - 1) ? 0 : m_pre[c] + 1;
        m_pend[c] = lw;
        if (lw) m_load[c] = bus_wdata;
        if (cw) m_ctrl[c] = nc;
        if (bw) m_bg[c] = bus_wdata;
      end
      m_raw = (m_raw & ~((bus_wr && bus_addr == 8'h0C) ? bus_wdata[3:0] : 4'h0)) | unf;
      if (bus_wr && bus_addr == 8'h00) m_mask = bus_wdata[3:0];
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // R13: interrupt line compared with the model on every clock
  always @(negedge clk) begin
    #2;
    if (rst_n && !ended) check("R13 irq", {31'd0, irq_o}, {31'd0, |(m_raw & m_mask)});
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input string req);
    bus_addr = a; #1;
    check(req, bus_rdata, mread(a));
  endtask

  task automatic rd_lit(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic run_cmp(input int n, input logic [7:0] a, input string req);
    repeat (n) begin
      @(negedge clk);
      rd_chk(a, req);
    end
  endtask

  task automatic finish_run();
    ended = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: everything zero after reset
    for (int a = 0; a <= 8'h4C; a += 4) rd_lit(8'(a), 32'd0, "R1 reset");
    check("R1 irq", {31'd0, irq_o}, 32'd0);

    // R3: load lands one edge after the write
    wr(8'h10, 32'd5);
    rd_lit(8'h14, 32'd0, "R3 old value");
    @(negedge clk); rd_lit(8'h14, 32'd5, "R3 new value");

    // R4 R5 R6: divide-by-1, 32-bit free run
    wr(8'h18, 32'h82);
    rd_lit(8'h14, 32'd5, "R6 no tick on write edge");
    @(negedge clk); rd_lit(8'h14, 32'd4, "R5 first tick");
    // R7 R8: underflow and 32-bit wrap
    run_cmp(8, 8'h14, "R8 wrap32");
    rd_chk(8'h04, "R7 raw");

    // R9: 16-bit periodic, divide-by-16
    wr(8'h2C, 32'd3);
    wr(8'h20, 32'd2);
    wr(8'h28, 32'hC4);
    run_cmp(120, 8'h24, "R9 periodic");
    // R10: background write mid count
    wr(8'h2C, 32'd7);
    rd_chk(8'h24, "R10 no immediate effect");
    run_cmp(200, 8'h24, "R10 later reload");

    // R11: one-shot holds at zero
    wr(8'h30, 32'd3);
    wr(8'h38, 32'h83);
    run_cmp(12, 8'h34, "R11 oneshot");
    rd_chk(8'h04, "R11 raw");
    wr(8'h0C, 32'h4);
    run_cmp(20, 8'h04, "R11 no second event");
    // R11: one-shot over periodic
    wr(8'h30, 32'd2);
    wr(8'h3C, 32'd9);
    wr(8'h38, 32'hC3);
    run_cmp(10, 8'h34, "R11 precedence");

    // R12: 16-bit with upper bits loaded
    wr(8'h40, 32'h1234_0002);
    wr(8'h48, 32'h80);
    run_cmp(8, 8'h44, "R12 width16");

    // R13: mask, masked status, clear
    wr(8'h00, 32'hF);
    rd_chk(8'h08, "R13 masked");
    rd_chk(8'h00, "R13 mask");
    wr(8'h0C, 32'hF);
    rd_chk(8'h04, "R13 clear");
    run_cmp(60, 8'h04, "R13 raw track");

    // R6: prescale change restarts, same fields do not
    wr(8'h48, 32'h88);
    run_cmp(600, 8'h44, "R6 div256");
    wr(8'h48, 32'h8A);
    run_cmp(300, 8'h44, "R6 no restart");
    wr(8'h48, 32'h8C);
    run_cmp(300, 8'h44, "R4 code11");

    // R5: disabled channel holds
    wr(8'h18, 32'h02);
    run_cmp(6, 8'h14, "R5 hold");

    // R2: readback masking, read-only and unmapped words
    wr(8'h38, 32'hFF);
    rd_lit(8'h38, 32'hCF, "R2 ctrl bits");
    wr(8'h04, 32'hF);
    rd_chk(8'h04, "R2 raw readonly");
    wr(8'h14, 32'h0);
    rd_chk(8'h14, "R2 value readonly");
    rd_lit(8'h50, 32'd0, "R2 unmapped");
    rd_lit(8'h11, 32'd0, "R2 unaligned");
    rd_lit(8'h0C, 32'd0, "R2 clear reads zero");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule